// File: doc/BRIEF.md
# Clock Slip Width Qualifier

This block decides whether a slip indication coming from a phase-locked loop is real. The raw slip arrives asynchronously. It is resynchronized into a low-frequency sampling clock of about 10 MHz. A down-counter then requires the slip to stay high for a programmed number of sampling cycles before the qualified output rises. Glitches shorter than that window never reach the output.

A single 32-bit configuration word sets the behaviour. It holds a 6-bit minimum-width threshold and a 4-bit arming key. Only privileged bus accesses can change it, while reads are always open. Qualification is armed only when the threshold is nonzero and the key holds something other than its reset code. In every other case the raw slip goes straight to the output without passing through any register. The configuration port works on the sampling clock.

Top module: `slip_width_filter`

## Requirements
- R1: After synchronous reset the configuration word reads 0x0000_0005 (threshold 0, key 5h), and the output follows the raw slip.
- R2: A privileged write (`bus_we`=1, `bus_priv`=1) stores `bus_wdata[13:8]` as the threshold and `bus_wdata[3:0]` as the key. Both can be read back at the same positions one cycle later.
- R3: Bits 31:14 and 7:4 of the read word are always 0, and writing ones to them has no effect.
- R4: A write with `bus_priv`=0 changes neither field, so both the read word and the output behaviour stay as they were.
- R5: While the key is 5h, `slip_out` equals `slip_raw` in the same cycle, whatever the threshold.
- R6: The key Fh is treated as disarmed, so `slip_out` equals `slip_raw`.
- R7: A threshold of 0 disarms qualification for every key value, and `slip_out` equals `slip_raw`.
- R8: When armed with threshold N, suppose the raw slip is first sampled high at rising edge e and stays high. Then `slip_out` rises after edge e+N+1. The two synchronizer stages account for two of those cycles.
- R9: With threshold 1, a raw slip that is high for a single sampling edge still produces an output pulse.
- R10: When armed with threshold N of 2 or more, a raw slip that is high for fewer than N consecutive sampling edges never raises `slip_out`.
- R11: When armed, suppose the raw slip is first sampled low at edge e. Then `slip_out` falls after edge e+2, and the counter reloads the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency sampling clock, also used by the configuration port |
| rst | input | 1 | Synchronous active-high reset |
| slip_raw | input | 1 | Asynchronous slip indication from the PLL |
| bus_we | input | 1 | Configuration write strobe |
| bus_priv | input | 1 | Marks the current access as privileged |
| bus_wdata | input | 32 | Configuration write data |
| bus_rdata | output | 32 | Configuration read data |
| slip_out | output | 1 | Qualified (or bypassed) slip |

## Verification
The bench builds the block with its default values: two synchronizer stages, a 6-bit threshold and a 32-bit word. With these values the whole threshold range is reachable, from the single-cycle case up to 63, and so are the pulses one cycle short of each threshold and exactly at it. A reference model keeps the raw slip history in the bench and predicts the output for every cycle. It covers the pass-through keys 5h and Fh, a zero threshold, and non-privileged write attempts, each seen at the output pin.

// File: rtl/slipf_pkg.sv
package slipf_pkg;

    localparam int SLIPF_REG_W   = 32;
    localparam int SLIPF_THR_W   = 6;
    localparam int SLIPF_KEY_W   = 4;
    localparam int SLIPF_THR_LSB = 8;
    localparam int SLIPF_KEY_LSB = 0;

    localparam logic [SLIPF_KEY_W-1:0] SLIPF_KEY_RESET = 4'h5;
    localparam logic [SLIPF_KEY_W-1:0] SLIPF_KEY_BAD   = 4'hF;

    typedef struct packed {
        logic [SLIPF_THR_W-1:0] thr;
        logic [SLIPF_KEY_W-1:0] key;
    } slipf_cfg_t;

    function automatic logic slipf_armed(slipf_cfg_t c);
        return (c.thr != '0) && (c.key != SLIPF_KEY_RESET) && (c.key != SLIPF_KEY_BAD);
    endfunction

endpackage

// File: rtl/slipf_sync.sv
module slipf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/slipf_cfg_reg.sv
module slipf_cfg_reg
    import slipf_pkg::*;
#(
    parameter int REG_W = SLIPF_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             priv,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output slipf_cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.thr <= '0;
            cfg.key <= SLIPF_KEY_RESET;
        end else if (we && priv) begin
            cfg.thr <= wdata[SLIPF_THR_LSB +: SLIPF_THR_W];
            cfg.key <= wdata[SLIPF_KEY_LSB +: SLIPF_KEY_W];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[SLIPF_THR_LSB +: SLIPF_THR_W] = cfg.thr;
        rdata[SLIPF_KEY_LSB +: SLIPF_KEY_W] = cfg.key;
    end

    // R2: privileged write lands in both fields on the next cycle
    assert_priv_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && priv) |=> (cfg.thr == $past(wdata[SLIPF_THR_LSB +: SLIPF_THR_W]) &&
                          cfg.key == $past(wdata[SLIPF_KEY_LSB +: SLIPF_KEY_W])));

    // R4: non-privileged write leaves the configuration untouched
    assert_nonpriv_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (we && !priv) |=> $stable({cfg.thr, cfg.key}));
endmodule

// File: rtl/slipf_width_cnt.sv
module slipf_width_cnt #(
    parameter int THR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slip_s,
    input  logic [THR_W-1:0] thr,
    output logic             det
);
    localparam logic [THR_W-1:0] TERMINAL = THR_W'(1);

    logic [THR_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            det    <= 1'b0;
        end else if (!slip_s) begin
            remain <= thr;
            det    <= 1'b0;
        end else if (remain <= TERMINAL) begin
            det    <= 1'b1;
        end else begin
            remain <= remain - TERMINAL;
        end
    end

    // R11: a low synchronized slip clears the detection one cycle later
    assert_drop_after_low_R11: assert property (@(posedge clk) disable iff (rst)
        !slip_s |=> !det);

    // R8: detection only rises after a cycle in which the slip was seen high
    assert_rise_needs_slip_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(det) |-> $past(slip_s));
endmodule

// File: rtl/slip_width_filter.sv
module slip_width_filter
    import slipf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = SLIPF_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slip_raw,
    input  logic             bus_we,
    input  logic             bus_priv,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             slip_out
);
    slipf_cfg_t cfg;
    logic       slip_s;
    logic       det;
    logic       armed;

    slipf_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .priv  (bus_priv),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    slipf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (slip_raw),
        .q   (slip_s)
    );

    slipf_width_cnt #(.THR_W(SLIPF_THR_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .slip_s (slip_s),
        .thr    (cfg.thr),
        .det    (det)
    );

    assign armed    = slipf_armed(cfg);
    assign slip_out = armed ? det : slip_raw;

    // R10: while armed across a cycle, a rising output needs the synchronized slip high before it
    assert_armed_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && $rose(slip_out)) |-> $past(slip_s));
endmodule

// File: tb/slip_width_filter_test.sv
module slip_width_filter_test;
    import slipf_pkg::*;

    localparam int CLK_PERIOD = 100;
    localparam int HIST_W     = 72;

    logic        clk = 1'b0;
    logic        rst;
    logic        raw;
    logic        we;
    logic        priv;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        out;

    always #(CLK_PERIOD/2) clk = ~clk;

    slip_width_filter uut (
        .clk       (clk),
        .rst       (rst),
        .slip_raw  (raw),
        .bus_we    (we),
        .bus_priv  (priv),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .slip_out  (out)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t              sbq[$];
    logic [HIST_W-1:0]  hist;
    int                 m_thr;
    int                 m_key;
    int                 tests = 0;
    int                 fails = 0;

    function automatic bit model_armed();
        return (m_thr != 0) && (m_key != 5) && (m_key != 15);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: set raw for the next edge and queue the predicted output
    task automatic drive(logic v, string tag);
        logic e;
        @(negedge clk);
        #1;
        raw  = v;
        hist = {hist[HIST_W-2:0], v};
        if (model_armed()) begin
            e = 1'b1;
            for (int k = 2; k <= m_thr + 1; k++) e = e & hist[k];
        end else begin
            e = v;
        end
        sbq.push_back('{e, tag});
    endtask

    task automatic pulse(int len, int gap, string thigh, string tlow);
        for (int i = 0; i < len; i++) drive(1'b1, thigh);
        for (int i = 0; i < gap; i++) drive(1'b0, tlow);
    endtask

    task automatic cfg_write(logic p, logic [31:0] d);
        for (int i = 0; i < 3; i++) drive(1'b0, "R11");
        @(negedge clk);
        #1;
        we = 1'b1; priv = p; wdata = d;
        @(negedge clk);
        #1;
        we = 1'b0; priv = 1'b0; wdata = '0;
        if (p) begin
            m_thr = int'(d[13:8]);
            m_key = int'(d[3:0]);
        end
        hist = '0;
    endtask

    // monitor: compare each queued prediction at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(it.tag, {31'd0, out}, {31'd0, it.exp});
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        tests++;
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; raw = 1'b0; we = 1'b0; priv = 1'b0; wdata = '0;
        hist = '0; m_thr = 0; m_key = 5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        rst = 1'b0;

        // R1: reset word and pass-through
        @(negedge clk);
        check("R1", rdata, 32'h0000_0005);
        pulse(1, 1, "R1", "R1");
        pulse(3, 2, "R1", "R1");

        // R5: key 5h bypasses even with a threshold
        cfg_write(1'b1, 32'h0000_0305);
        @(negedge clk);
        check("R2", rdata, 32'h0000_0305);
        pulse(1, 2, "R5", "R5");
        pulse(2, 2, "R5", "R5");

        // R6: key Fh is disarmed
        cfg_write(1'b1, 32'h0000_030F);
        pulse(1, 2, "R6", "R6");
        pulse(4, 2, "R6", "R6");

        // R7: zero threshold is disarmed
        cfg_write(1'b1, 32'h0000_000A);
        @(negedge clk);
        check("R7", rdata, 32'h0000_000A);
        pulse(1, 2, "R7", "R7");

        // R4: non-privileged write has no effect
        cfg_write(1'b0, 32'h0000_0207);
        @(negedge clk);
        check("R4", rdata, 32'h0000_000A);
        pulse(1, 2, "R4", "R4");
        pulse(2, 2, "R4", "R4");

        // R3: reserved bits
        cfg_write(1'b1, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R3", rdata, 32'h0000_3F0F);

        // R2: field positions
        cfg_write(1'b1, 32'h0000_2A0A);
        @(negedge clk);
        check("R2", rdata, 32'h0000_2A0A);

        // R8 / R10 / R11 with threshold 5
        cfg_write(1'b1, 32'h0000_050A);
        pulse(9, 6, "R8", "R11");
        pulse(5, 6, "R8", "R11");
        pulse(4, 6, "R10", "R10");
        pulse(1, 6, "R10", "R10");

        // R9: threshold 1 passes single-cycle slips
        cfg_write(1'b1, 32'h0000_010A);
        pulse(1, 4, "R9", "R11");
        pulse(1, 3, "R9", "R11");
        pulse(3, 4, "R9", "R11");

        // R10 / R8 at the top of the range
        cfg_write(1'b1, 32'h0000_3F0A);
        pulse(62, 6, "R10", "R10");
        pulse(63, 6, "R8", "R11");
        pulse(66, 6, "R8", "R11");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule